// File: doc/BRIEF.md
# Segmented Tag-Compare Instruction Cache

A read-only instruction cache of 16 KB. It is built as 8 segments. Each segment holds 64 lines of 8 32-bit words. Address bits [7:5] pick the segment. Inside that segment, every line's stored tag (address bits [31:8]) is compared in parallel with the fetch address, so any line can hold any block that maps to the segment. On a hit, the addressed word is read out and reduced to a byte, halfword or word. On a miss, the block reads the whole line from memory as 8 sequential single-word reads. It then installs the line in the slot picked by that segment's round-robin pointer and returns the requested data.

Each fetch carries a cacheable flag. When that flag is low, or the cache is turned off, the fetch is served by one single-word memory read and the arrays are left untouched. Turning the cache off does not clear it, so lines that were present before can hit again once it is turned back on. Only the separate invalidate command clears every valid bit. The fetch side and the memory side are both plain request/response ports.

Top module: `icache_seg`

## Requirements
- R1: After reset every line is invalid and the cache is off. A fetch then causes exactly one memory read, `req_ready_o` is 1 and `resp_valid_o` is 0.
- R2: An enabled, cacheable fetch that misses issues 8 memory reads to the line base plus 0, 4, ... 28, in that order. The requested data is returned only after the eighth read.
- R3: An enabled, cacheable fetch that finds a valid line with a matching tag in its segment returns data on `resp_valid_o` in the cycle after acceptance and issues no memory read.
- R4: `req_size_i` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A byte is word bits [8*a+7:8*a] with a = addr[1:0]. A halfword is bits [15:0] if addr[1]=0 and bits [31:16] otherwise. The result is zero-extended.
- R5: While the cache is off, each fetch makes one memory read at the word-aligned address and leaves the arrays unchanged. A block fetched while off still misses after the cache is turned back on.
- R6: Turning the cache off and on again keeps the lines that were present before, and they hit.
- R7: `inval_i` clears every valid bit, so a line that hit before now misses.
- R8: A fetch with `req_cacheable_i`=0 bypasses the cache while it is enabled (one read, no install). A later cacheable fetch of the same block misses.
- R9: Address bits [7:5] select the segment. The same tag in a different segment misses. Up to 64 blocks with distinct tags can be resident in one segment at once.
- R10: Each segment replaces lines in round-robin order 0..63. The 65th distinct fill of a segment evicts the first block filled and keeps the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Strobe that loads the enable bit |
| en_val_i | input | 1 | New enable value (1 = on) |
| inval_i | input | 1 | Clear all valid bits |
| req_valid_i | input | 1 | Fetch request |
| req_ready_o | output | 1 | Fetch accepted when high with request |
| req_addr_i | input | 32 | Fetch byte address |
| req_size_i | input | 2 | Access size code |
| req_cacheable_i | input | 1 | Region may be cached |
| resp_valid_o | output | 1 | Response data valid (one cycle) |
| resp_data_o | output | 32 | Fetched data, zero-extended |
| mem_req_o | output | 1 | Memory read request, held until `mem_rvalid_i` |
| mem_addr_o | output | 32 | Word-aligned memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid, completes the request |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
A bad valid bit, tag or round-robin pointer has two visible effects. The number of memory reads for a fetch changes: 0 becomes 8 or 8 becomes 0. The response also arrives one cycle after acceptance instead of after the fill, or the other way round. A wrong line or word index shows up as a wrong data value on the same response. Every fetch's read count and data are compared against a memory model, so a wrong state is seen at the first fetch that touches the affected block. A stale enable or a missing invalidate is seen at the next fetch after the command.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } fetch_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYP,
    ST_DONE
  } ic_state_e;
endpackage

// File: rtl/icache_tag_cam.sv
module icache_tag_cam #(
  parameter int NUM_SEG = 8,
  parameter int LINES   = 64,
  parameter int TAG_W   = 24,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic [SEG_W-1:0]  lk_seg_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] hit_line_o,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  output logic [LINE_W-1:0] wr_line_o
);
  logic [LINES-1:0]  valid_q [NUM_SEG];
  logic [TAG_W-1:0]  tag_q   [NUM_SEG][LINES];
  logic [LINE_W-1:0] rr_q    [NUM_SEG];
  logic [LINES-1:0]  match;

  for (genvar l = 0; l < LINES; l++) begin : g_cmp
    assign match[l] = valid_q[lk_seg_i][l] && (tag_q[lk_seg_i][l] == lk_tag_i);
  end

  always_comb begin
    hit_line_o = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (match[l]) hit_line_o = LINE_W'(l);
    end
  end

  assign hit_o     = |match;
  assign wr_line_o = rr_q[wr_seg_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SEG; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      if (inval_i) begin
        for (int s = 0; s < NUM_SEG; s++) valid_q[s] <= '0;
      end else if (wr_en_i) begin
        valid_q[wr_seg_i][rr_q[wr_seg_i]] <= 1'b1;
      end
      if (wr_en_i) rr_q[wr_seg_i] <= rr_q[wr_seg_i] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_seg_i][rr_q[wr_seg_i]] <= wr_tag_i;
  end

  // R9: a tag can live in at most one line of a segment
  p_single_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R7: invalidate leaves no line valid
  p_inval_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (valid_q[lk_seg_i] == '0));
endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
  parameter int NUM_SEG = 8,
  parameter int LINES   = 64,
  parameter int WORDS   = 8,
  parameter int DATA_W  = 32,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int LINE_W = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int DEPTH  = NUM_SEG * LINES * WORDS
) (
  input  logic                         clk_i,
  input  logic                         wr_en_i,
  input  logic [SEG_W-1:0]             wr_seg_i,
  input  logic [LINE_W-1:0]            wr_line_i,
  input  logic [WORDS-1:0][DATA_W-1:0] wr_data_i,
  input  logic [SEG_W-1:0]             rd_seg_i,
  input  logic [LINE_W-1:0]            rd_line_i,
  input  logic [WORD_W-1:0]            rd_word_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int w = 0; w < WORDS; w++) begin
        mem_q[{wr_seg_i, wr_line_i, WORD_W'(w)}] <= wr_data_i[w];
      end
    end
  end

  assign rd_data_o = mem_q[{rd_seg_i, rd_line_i, rd_word_i}];
endmodule

// File: rtl/icache_byte_sel.sv
module icache_byte_sel
  import icache_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  output logic [31:0] data_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {24'h0, word_i[8*off_i +: 8]};
      SZ_HALF: data_o = {16'h0, off_i[1] ? word_i[31:16] : word_i[15:0]};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/icache_seg.sv
module icache_seg
  import icache_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int LINES   = 64,
  parameter int WORDS   = 8,
  parameter int ADDR_W  = 32,
  localparam int DATA_W = 32,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int LINE_W = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int SEG_LO = WORD_W + 2,
  localparam int TAG_LO = SEG_LO + SEG_W,
  localparam int TAG_W  = ADDR_W - TAG_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              inval_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_cacheable_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  ic_state_e                  state_q, state_d;
  logic                       en_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [1:0]                 size_q;
  logic [WORD_W-1:0]          wcnt_q;
  logic [WORDS-1:0][DATA_W-1:0] buf_q;
  logic                       resp_valid_q, resp_valid_d;
  logic [DATA_W-1:0]          resp_data_q;

  logic                       accept, lookup, cam_hit, line_wr;
  logic [LINE_W-1:0]          hit_line, wr_line;
  logic [DATA_W-1:0]          ram_word, sel_word, sel_data;
  logic [1:0]                 sel_off, sel_size;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign lookup      = en_q && req_cacheable_i;
  assign line_wr     = (state_q == ST_DONE);

  icache_tag_cam #(.NUM_SEG(NUM_SEG), .LINES(LINES), .TAG_W(TAG_W)) u_cam (
    .clk_i, .rst_ni, .inval_i,
    .lk_seg_i   (req_addr_i[TAG_LO-1:SEG_LO]),
    .lk_tag_i   (req_addr_i[ADDR_W-1:TAG_LO]),
    .hit_o      (cam_hit),
    .hit_line_o (hit_line),
    .wr_en_i    (line_wr),
    .wr_seg_i   (addr_q[TAG_LO-1:SEG_LO]),
    .wr_tag_i   (addr_q[ADDR_W-1:TAG_LO]),
    .wr_line_o  (wr_line)
  );

  icache_data_ram #(.NUM_SEG(NUM_SEG), .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk_i,
    .wr_en_i   (line_wr),
    .wr_seg_i  (addr_q[TAG_LO-1:SEG_LO]),
    .wr_line_i (wr_line),
    .wr_data_i (buf_q),
    .rd_seg_i  (req_addr_i[TAG_LO-1:SEG_LO]),
    .rd_line_i (hit_line),
    .rd_word_i (req_addr_i[SEG_LO-1:2]),
    .rd_data_o (ram_word)
  );

  // one selector shared by hit, fill-done and bypass paths
  always_comb begin
    sel_off  = addr_q[1:0];
    sel_size = size_q;
    unique case (state_q)
      ST_IDLE: begin
        sel_word = ram_word;
        sel_off  = req_addr_i[1:0];
        sel_size = req_size_i;
      end
      ST_DONE: sel_word = buf_q[addr_q[SEG_LO-1:2]];
      default: sel_word = mem_rdata_i;
    endcase
  end

  icache_byte_sel u_sel (
    .word_i (sel_word),
    .off_i  (sel_off),
    .size_i (sel_size),
    .data_o (sel_data)
  );

  always_comb begin
    state_d      = state_q;
    resp_valid_d = 1'b0;
    mem_req_o    = 1'b0;
    mem_addr_o   = {addr_q[ADDR_W-1:2], 2'b00};
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (lookup && cam_hit) resp_valid_d = 1'b1;
        else if (lookup)       state_d = ST_FILL;
        else                   state_d = ST_BYP;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {addr_q[ADDR_W-1:SEG_LO], wcnt_q, 2'b00};
        if (mem_rvalid_i && (wcnt_q == WORD_W'(WORDS - 1))) state_d = ST_DONE;
      end
      ST_BYP: begin
        mem_req_o = 1'b1;
        if (mem_rvalid_i) begin
          resp_valid_d = 1'b1;
          state_d      = ST_IDLE;
        end
      end
      ST_DONE: begin
        resp_valid_d = 1'b1;
        state_d      = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      en_q         <= 1'b0;
      addr_q       <= '0;
      size_q       <= '0;
      wcnt_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= resp_valid_d;
      if (resp_valid_d) resp_data_q <= sel_data;
      if (en_wr_i) en_q <= en_val_i;
      if (accept) begin
        addr_q <= req_addr_i;
        size_q <= req_size_i;
        wcnt_q <= '0;
      end else if (state_q == ST_FILL && mem_rvalid_i) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == ST_FILL && mem_rvalid_i) buf_q[wcnt_q] <= mem_rdata_i;
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_data_o  = resp_data_q;

  // R2: fill walks the line one word at a time
  p_fill_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_rvalid_i && wcnt_q != WORD_W'(WORDS - 1))
    |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  // R3: hit answers in the next cycle with the port free again
  p_hit_next_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_q && req_cacheable_i && cam_hit) |=> (resp_valid_o && req_ready_o));

  // R5: uncached access is a single read followed by the response
  p_bypass_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYP && mem_rvalid_i) |=> (!mem_req_o && resp_valid_o));

  // R2: data is not returned while a fill is still reading
  p_no_early_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |-> !resp_valid_o);
endmodule

// File: tb/icache_seg_tb_top.sv
`timescale 1ns/1ps
module icache_seg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_wr_i = 1'b0, en_val_i = 1'b0, inval_i = 1'b0;
  logic        req_valid_i = 1'b0, req_cacheable_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_ready_o, resp_valid_o, mem_req_o;
  logic [31:0] resp_data_o, mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [64];

  always #2.5 clk_i = ~clk_i;

  icache_seg dut_i (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a ^ 32'h5A5A_C3C3) * 32'h0001_0193) + 32'h0000_0007;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = mem_word({a[31:2], 2'b00});
    case (sz)
      2'd0:    return {24'h0, w[8*a[1:0] +: 8]};
      2'd1:    return {16'h0, a[1] ? w[31:16] : w[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: answers each held request one cycle after it appears
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_rvalid_i) mem_rvalid_i = 1'b0;
      else if (mem_req_o) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_word(mem_addr_o);
        rd_log[rd_cnt % 64] = mem_addr_o;
        rd_cnt++;
      end
    end
  end

  int last_base;
  task automatic fetch(input logic [31:0] a, input logic [1:0] sz, input bit c,
                       output logic [31:0] d, output int nrd, output int lat);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    last_base = rd_cnt;
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz; req_cacheable_i = c;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    while (!resp_valid_o && lat < 200) begin
      @(negedge clk_i);
      lat++;
    end
    d = resp_data_o;
    nrd = rd_cnt - last_base;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk_i); en_wr_i = 1'b1; en_val_i = v;
    @(negedge clk_i); en_wr_i = 1'b0;
  endtask

  task automatic run_chk(input logic [31:0] a, input logic [1:0] sz, input bit c,
                         input int exp_rd, input string req);
    logic [31:0] d; int nrd, lat;
    fetch(a, sz, c, d, nrd, lat);
    check(nrd == exp_rd, {req, " reads"}, nrd, exp_rd);
    check(d == exp_data(a, sz), {req, " data"}, d, exp_data(a, sz));
    if (exp_rd == 0) check(lat == 1, {req, " hit latency"}, lat, 1);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        cach;
    logic [3:0]  nrd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1004, 2'd2, 1'b1, 4'd8},  // R2 miss fill
    '{32'h0000_1010, 2'd1, 1'b1, 4'd0},  // R3 R4 low half
    '{32'h0000_1012, 2'd1, 1'b1, 4'd0},  // R4 high half
    '{32'h0000_1013, 2'd0, 1'b1, 4'd0},  // R4 byte 3
    '{32'h0000_1021, 2'd0, 1'b1, 4'd8},  // R9 same tag, segment 1
    '{32'h0000_2004, 2'd3, 1'b1, 4'd8},  // R9 second tag, segment 0
    '{32'h0000_1008, 2'd2, 1'b1, 4'd0},  // R9 both resident
    '{32'h0000_3000, 2'd2, 1'b0, 4'd1},  // R8 uncached while enabled
    '{32'h0000_3000, 2'd2, 1'b1, 4'd8}   // R8 not installed
  };

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d; int nrd, lat;
    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1 ready in reset", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(resp_valid_o == 1'b0, "R1 no response after reset", resp_valid_o, 0);
    run_chk(32'h0000_1004, 2'd2, 1'b1, 1, "R1 disabled after reset");

    set_en(1'b1);
    for (int i = 0; i < NV; i++) begin
      run_chk(VECS[i].addr, VECS[i].size, VECS[i].cach, int'(VECS[i].nrd), $sformatf("vec%0d", i));
      if (i == 0) begin
        for (int k = 0; k < 8; k++)
          check(rd_log[(last_base + k) % 64] == 32'h0000_1000 + 32'(4 * k), "R2 fill order",
                rd_log[(last_base + k) % 64], 32'h0000_1000 + 32'(4 * k));
      end
    end

    // R5 disabled: contents ignored, word-aligned single read, no install
    set_en(1'b0);
    run_chk(32'h0000_1006, 2'd1, 1'b1, 1, "R5 off ignores hit");
    check(rd_log[last_base % 64] == 32'h0000_1004, "R5 aligned address", rd_log[last_base % 64], 32'h0000_1004);
    run_chk(32'h0000_5000, 2'd2, 1'b1, 1, "R5 off single read");
    set_en(1'b1);
    run_chk(32'h0000_1004, 2'd2, 1'b1, 0, "R6 kept after re-enable");
    run_chk(32'h0000_5000, 2'd2, 1'b1, 8, "R5 not installed while off");

    // R7 invalidate
    @(negedge clk_i); inval_i = 1'b1;
    @(negedge clk_i); inval_i = 1'b0;
    run_chk(32'h0000_1004, 2'd2, 1'b1, 8, "R7 miss after invalidate");

    // R9 / R10 in segment 3
    for (int t = 0; t < 64; t++)
      run_chk({16'h0, 8'(t + 1), 8'h60}, 2'd2, 1'b1, 8, "R9 fill segment");
    for (int t = 0; t < 64; t++) begin
      fetch({16'h0, 8'(t + 1), 8'h60}, 2'd2, 1'b1, d, nrd, lat);
      if (nrd != 0) check(1'b0, "R9 64 lines resident", nrd, 0);
    end
    check(1'b1, "R9 64 lines resident", 0, 0);
    run_chk(32'h0001_0060, 2'd2, 1'b1, 8, "R10 65th fill");
    run_chk(32'h0000_0260, 2'd2, 1'b1, 0, "R10 second block kept");
    run_chk(32'h0000_0160, 2'd2, 1'b1, 8, "R10 first block evicted");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule